// File: doc/BRIEF.md
# Dual-Register Output Compare Channel

This block is one compare channel that watches a free-running timer count and drives one output pin. A configuration write picks one of two timebases and one of eight operating modes. Each timebase gives a count and a period strobe. The modes cover three kinds of behaviour. The first is a single compare that sets, clears or toggles the pin. The second is pulse generation from two registers: a primary register starts the pulse and a secondary register ends it. The third is pulse-width modulation, where the secondary register holds the next duty value and a fault input can force the pin off.

The pin comes from a registered set/reset latch. Each qualifying event sets a sticky interrupt flag, and a separate strobe clears it. A compare hit counts only on the first clock in which the selected count equals the register value. A count that stays at that value does not trigger again.

Top module: `oc_channel`

## Requirements
- R1: After reset the pin, the interrupt flag and the fault flag read 0, and the mode is 000 (off).
- R2: With `cfg_tsel`=0 the channel compares against `tmr_a` and uses `prd_a`. With `cfg_tsel`=1 it uses `tmr_b` and `prd_b`. The unselected timer has no effect.
- R3: A primary or secondary hit is taken only on the first clock in which the selected count equals the register. Holding the count at that value does not trigger again.
- R4: Mode 001 sets the pin on a primary hit, mode 010 clears it, and mode 011 inverts it. The pin changes at the clock edge that samples the hit.
- R5: Mode 000 drives the pin low from the next edge on and raises no interrupt.
- R6: In modes 100 and 101 a primary hit sets the pin and a secondary hit clears it. Mode 100 ignores further primary hits after the first secondary hit, until a configuration write re-arms it. Mode 101 repeats without limit.
- R7: In modes 110 and 111 the selected period strobe sets the pin and copies the secondary register into the primary register. A later primary hit clears the pin. The period strobe wins over a primary hit in the same cycle.
- R8: In mode 111 a low `fault_n` forces the pin low and sets `fault_flag`. The pin stays low until a configuration write clears the flag. In mode 110 `fault_n` has no effect.
- R9: `irq_flag` is set by these events: a primary hit in modes 001 to 011, a secondary hit in modes 100 and 101, a period strobe in modes 110 and 111, and a fault trip. The flag holds until `irq_clr`. A new event in the same cycle as `irq_clr` wins over the clear.
- R10: A configuration write changes the mode and timebase from the next clock. Events in the write cycle follow the previous settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_a | input | W | Count of timebase A |
| tmr_b | input | W | Count of timebase B |
| prd_a | input | 1 | Period strobe of timebase A |
| prd_b | input | 1 | Period strobe of timebase B |
| cfg_wr | input | 1 | Configuration write strobe; also re-arms and clears fault |
| cfg_mode | input | 3 | Mode value written by cfg_wr |
| cfg_tsel | input | 1 | Timebase select written by cfg_wr |
| pri_wr | input | 1 | Primary register write strobe |
| pri_in | input | W | Primary register write data |
| sec_wr | input | 1 | Secondary register write strobe |
| sec_in | input | W | Secondary register write data |
| fault_n | input | 1 | Active-low fault input |
| irq_clr | input | 1 | Interrupt flag clear strobe |
| pin | output | 1 | Compare output |
| irq_flag | output | 1 | Sticky interrupt flag |
| fault_flag | output | 1 | Latched fault status |

## Verification
The assertions assume three things about the inputs. The mode only changes through `cfg_wr`. `fault_flag` can only become set while the mode is 111. Reset starts with mode 000, so no event can precede the first configuration. The stimulus keeps timer counts and register values apart wherever a primary hit and a secondary hit could coincide. It changes every input half a cycle away from the sampling edge, and it raises a period strobe only on a cycle where the count is fresh. This way each expected pin value follows from exactly one event.

// File: rtl/oc_pkg.sv
package oc_pkg;
   typedef enum logic [2:0] {
      OC_OFF  = 3'b000,
      OC_SET  = 3'b001,
      OC_CLR  = 3'b010,
      OC_TGL  = 3'b011,
      OC_ONE  = 3'b100,
      OC_RPT  = 3'b101,
      OC_PWM  = 3'b110,
      OC_PWMF = 3'b111
   } oc_mode_e;
endpackage

// File: rtl/oc_tbase_mux.sv
module oc_tbase_mux #(
   parameter int W = 16
) (
   input  logic [W-1:0] cnt_a,
   input  logic [W-1:0] cnt_b,
   input  logic         prd_a,
   input  logic         prd_b,
   input  logic         sel,
   output logic [W-1:0] cnt,
   output logic         prd
);
   always_comb begin
      cnt = sel ? cnt_b : cnt_a;
      prd = sel ? prd_b : prd_a;
   end
endmodule

// File: rtl/oc_match_det.sv
module oc_match_det #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] ref_val,
   output logic         hit
);
   logic eq_now, eq_prev;

   always_comb eq_now = (cnt == ref_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) eq_prev <= 1'b0;
      else        eq_prev <= eq_now;
   end

   always_comb hit = eq_now & ~eq_prev;
endmodule

// File: rtl/oc_pin_latch.sv
module oc_pin_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic force_lo,
   input  logic set_i,
   input  logic rst_i,
   input  logic tgl_i,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (force_lo) q <= 1'b0;
      else if (rst_i)    q <= 1'b0;
      else if (set_i)    q <= 1'b1;
      else if (tgl_i)    q <= ~q;
   end
endmodule

// File: rtl/oc_channel.sv
module oc_channel
   import oc_pkg::*;
#(
   parameter int W         = 16,
   parameter bit HAS_FAULT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] tmr_a,
   input  logic [W-1:0] tmr_b,
   input  logic         prd_a,
   input  logic         prd_b,
   input  logic         cfg_wr,
   input  logic [2:0]   cfg_mode,
   input  logic         cfg_tsel,
   input  logic         pri_wr,
   input  logic [W-1:0] pri_in,
   input  logic         sec_wr,
   input  logic [W-1:0] sec_in,
   input  logic         fault_n,
   input  logic         irq_clr,
   output logic         pin,
   output logic         irq_flag,
   output logic         fault_flag
);
   localparam int CNT_MSB = W - 1;

   if (W < 2) begin : g_bad_width
      $error("oc_channel: W must be at least 2");
   end

   oc_mode_e           mode_q;
   logic               tsel_q;
   logic               armed_q;
   logic [CNT_MSB:0]   pri_q, sec_q;
   logic [CNT_MSB:0]   cnt_sel;
   logic               prd_sel;
   logic               hit_pri, hit_sec;
   logic               do_set, do_rst, do_tgl, do_force;
   logic               evt, disarm, duty_load;
   logic               fault_q, fault_trip;

   // configuration and compare registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= OC_OFF;
         tsel_q  <= 1'b0;
         armed_q <= 1'b1;
      end else if (cfg_wr) begin
         mode_q  <= oc_mode_e'(cfg_mode);
         tsel_q  <= cfg_tsel;
         armed_q <= 1'b1;
      end else if (disarm) begin
         armed_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pri_q <= '0;
         sec_q <= '0;
      end else begin
         if (pri_wr)         pri_q <= pri_in;
         else if (duty_load) pri_q <= sec_q;
         if (sec_wr)         sec_q <= sec_in;
      end
   end

   oc_tbase_mux #(.W(W)) u_tbase (
      .cnt_a(tmr_a), .cnt_b(tmr_b), .prd_a(prd_a), .prd_b(prd_b),
      .sel(tsel_q), .cnt(cnt_sel), .prd(prd_sel)
   );

   oc_match_det #(.W(W)) u_hit_pri (
      .clk(clk), .rst_n(rst_n), .cnt(cnt_sel), .ref_val(pri_q), .hit(hit_pri)
   );

   oc_match_det #(.W(W)) u_hit_sec (
      .clk(clk), .rst_n(rst_n), .cnt(cnt_sel), .ref_val(sec_q), .hit(hit_sec)
   );

   // fault handling variant
   if (HAS_FAULT) begin : g_fault
      always_comb fault_trip = (mode_q == OC_PWMF) && !fault_n;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          fault_q <= 1'b0;
         else if (cfg_wr)     fault_q <= 1'b0;
         else if (fault_trip) fault_q <= 1'b1;
      end
   end else begin : g_nofault
      always_comb fault_trip = 1'b0;
      always_comb fault_q    = 1'b0;
   end

   // mode decode
   always_comb begin
      do_set    = 1'b0;
      do_rst    = 1'b0;
      do_tgl    = 1'b0;
      do_force  = 1'b0;
      evt       = 1'b0;
      disarm    = 1'b0;
      duty_load = 1'b0;
      unique case (mode_q)
         OC_OFF: do_force = 1'b1;
         OC_SET: begin do_set = hit_pri; evt = hit_pri; end
         OC_CLR: begin do_rst = hit_pri; evt = hit_pri; end
         OC_TGL: begin do_tgl = hit_pri; evt = hit_pri; end
         OC_ONE: begin
            do_set = hit_pri & armed_q;
            do_rst = hit_sec & armed_q;
            evt    = hit_sec & armed_q;
            disarm = hit_sec & armed_q;
         end
         OC_RPT: begin
            do_set = hit_pri;
            do_rst = hit_sec;
            evt    = hit_sec;
         end
         OC_PWM, OC_PWMF: begin
            do_set    = prd_sel;
            do_rst    = hit_pri & ~prd_sel;
            evt       = prd_sel;
            duty_load = prd_sel;
            if (fault_trip || fault_q) do_force = 1'b1;
            if (fault_trip && !fault_q) evt = 1'b1;
         end
         default: do_force = 1'b1;
      endcase
   end

   oc_pin_latch u_latch (
      .clk(clk), .rst_n(rst_n), .force_lo(do_force),
      .set_i(do_set), .rst_i(do_rst), .tgl_i(do_tgl), .q(pin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       irq_flag <= 1'b0;
      else if (evt)     irq_flag <= 1'b1;
      else if (irq_clr) irq_flag <= 1'b0;
   end

   assign fault_flag = fault_q;
endmodule

// File: rtl/oc_channel_chk.sv
module oc_channel_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] mode_q,
   input logic       pin,
   input logic       irq_flag,
   input logic       fault_flag,
   input logic       cfg_wr,
   input logic       irq_clr
);
   AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q == 3'b000 |=> pin == 1'b0); // R5

   AST_FAULT_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      fault_flag |-> pin == 1'b0); // R8

   AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      fault_flag && !cfg_wr |=> fault_flag); // R8

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      irq_flag && !irq_clr |=> irq_flag); // R9

   AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flag) |-> $past(mode_q) != 3'b000); // R9
endmodule

bind oc_channel oc_channel_chk u_chk (
   .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .pin(pin),
   .irq_flag(irq_flag), .fault_flag(fault_flag),
   .cfg_wr(cfg_wr), .irq_clr(irq_clr)
);

// File: tb/oc_channel_test.sv
`timescale 1ns/1ps
module oc_channel_test;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] tmr_a = '0, tmr_b = '0;
   logic         prd_a = 1'b0, prd_b = 1'b0;
   logic         cfg_wr = 1'b0;
   logic [2:0]   cfg_mode = 3'b000;
   logic         cfg_tsel = 1'b0;
   logic         pri_wr = 1'b0, sec_wr = 1'b0;
   logic [W-1:0] pri_in = '0, sec_in = '0;
   logic         fault_n = 1'b1;
   logic         irq_clr = 1'b0;
   logic         pin, irq_flag, fault_flag;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [2:0] exp_q[$];
   string      tag_q[$];
   logic       e_pin = 1'b0, e_irq = 1'b0, e_flt = 1'b0;

   always #4 clk = ~clk;

   oc_channel #(.W(W)) uut (
      .clk(clk), .rst_n(rst_n), .tmr_a(tmr_a), .tmr_b(tmr_b),
      .prd_a(prd_a), .prd_b(prd_b), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
      .cfg_tsel(cfg_tsel), .pri_wr(pri_wr), .pri_in(pri_in),
      .sec_wr(sec_wr), .sec_in(sec_in), .fault_n(fault_n),
      .irq_clr(irq_clr), .pin(pin), .irq_flag(irq_flag),
      .fault_flag(fault_flag)
   );

   // monitor: compares outputs half a cycle after each edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [2:0] e;
         string      t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if ({pin, irq_flag, fault_flag} !== e) begin
            failures++;
            $display("FAIL %s: pin/irq/fault actual=%b expected=%b", t,
                     {pin, irq_flag, fault_flag}, e);
         end
      end
   end

   // driver: one clock edge, then push the expected outputs
   task automatic cyc(input string tag);
      @(posedge clk);
      exp_q.push_back({e_pin, e_irq, e_flt});
      tag_q.push_back(tag);
      @(negedge clk);
      pri_wr  = 1'b0;
      sec_wr  = 1'b0;
      cfg_wr  = 1'b0;
      irq_clr = 1'b0;
   endtask

   task automatic cfg(input logic [2:0] m, input logic ts, input string tag);
      cfg_wr = 1'b1; cfg_mode = m; cfg_tsel = ts;
      cyc(tag);
   endtask

   task automatic clr(input string tag);
      irq_clr = 1'b1; e_irq = 1'b0;
      cyc(tag);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      cyc("R1");

      pri_wr = 1'b1; pri_in = 16'd100; sec_wr = 1'b1; sec_in = 16'd200;
      cyc("R5");
      tmr_a = 16'd100; cyc("R5 off mode hit ignored");
      tmr_a = 16'd0;   cyc("R5");

      // single match set
      cfg(3'b001, 1'b0, "R10");
      tmr_a = 16'd100; e_pin = 1'b1; e_irq = 1'b1; cyc("R4 set");
      clr("R9 clear");

      // held count does not retrigger
      cfg(3'b011, 1'b0, "R3");
      cyc("R3 held count");
      tmr_a = 16'd101; cyc("R3");
      tmr_a = 16'd100; e_pin = 1'b0; e_irq = 1'b1; cyc("R4 toggle");
      clr("R9");
      tmr_a = 16'd101; cyc("R4");
      tmr_a = 16'd100; e_pin = 1'b1; e_irq = 1'b1; cyc("R4 toggle up");
      clr("R9");
      cfg(3'b010, 1'b0, "R10");
      tmr_a = 16'd101; cyc("R4");
      tmr_a = 16'd100; e_pin = 1'b0; e_irq = 1'b1; cyc("R4 clear");
      clr("R9");

      // timebase select
      cfg(3'b001, 1'b1, "R2");
      tmr_b = 16'd5; cyc("R2 timer A ignored");
      tmr_b = 16'd100; e_pin = 1'b1; e_irq = 1'b1; cyc("R2 timer B hit");
      clr("R9");

      // dual match continuous
      cfg(3'b101, 1'b0, "R6");
      tmr_a = 16'd0;   cyc("R6");
      tmr_a = 16'd200; e_pin = 1'b0; e_irq = 1'b1; cyc("R6 secondary clears");
      clr("R9");
      tmr_a = 16'd100; e_pin = 1'b1; cyc("R6 primary sets");
      tmr_a = 16'd200; e_pin = 1'b0; e_irq = 1'b1; cyc("R6 repeat");
      clr("R9");

      // dual match one shot
      cfg(3'b100, 1'b0, "R6");
      tmr_a = 16'd100; e_pin = 1'b1; cyc("R6 one-shot set");
      tmr_a = 16'd200; e_pin = 1'b0; e_irq = 1'b1; cyc("R6 one-shot end");
      clr("R9");
      tmr_a = 16'd100; cyc("R6 disarmed");
      tmr_a = 16'd200; cyc("R6 disarmed no irq");
      cfg(3'b100, 1'b0, "R6 rearm");
      tmr_a = 16'd100; e_pin = 1'b1; cyc("R6 rearmed");

      // PWM without fault
      sec_wr = 1'b1; sec_in = 16'd30;
      cfg(3'b110, 1'b0, "R10");
      tmr_a = 16'd0; prd_a = 1'b1; e_irq = 1'b1; cyc("R7 period set");
      prd_a = 1'b0; tmr_a = 16'd29; cyc("R7");
      tmr_a = 16'd30; e_pin = 1'b0; cyc("R7 duty match");
      clr("R9");
      tmr_a = 16'd31; sec_wr = 1'b1; sec_in = 16'd50; cyc("R7");
      tmr_a = 16'd0; prd_a = 1'b1; e_pin = 1'b1; e_irq = 1'b1; cyc("R7 period");
      prd_a = 1'b0; tmr_a = 16'd30; cyc("R7 reloaded duty");
      tmr_a = 16'd50; e_pin = 1'b0; cyc("R7 new duty match");
      fault_n = 1'b0; tmr_a = 16'd0; prd_a = 1'b1; e_pin = 1'b1;
      cyc("R8 fault ignored in 110");
      fault_n = 1'b1; prd_a = 1'b0; tmr_a = 16'd1;
      clr("R9");
      tmr_a = 16'd0; prd_a = 1'b1; irq_clr = 1'b1; e_irq = 1'b1;
      cyc("R9 set wins over clear");
      prd_a = 1'b0;

      // PWM with fault
      cfg(3'b111, 1'b0, "R10");
      fault_n = 1'b0; tmr_a = 16'd5; e_pin = 1'b0; e_flt = 1'b1;
      cyc("R8 fault trips");
      fault_n = 1'b1; cyc("R8 fault latched");
      tmr_a = 16'd0; prd_a = 1'b1; cyc("R8 pin held low");
      prd_a = 1'b0;
      cfg(3'b111, 1'b0, "R8 cleared by write"); e_flt = 1'b0;
      exp_q[exp_q.size()-1] = {e_pin, e_irq, e_flt};
      tmr_a = 16'd0; prd_a = 1'b1; e_pin = 1'b1; cyc("R8 recovery");
      prd_a = 1'b0;

      // back to off
      cfg(3'b000, 1'b0, "R10");
      e_pin = 1'b0; cyc("R5 off forces low");

      @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule